// File: doc/BRIEF.md
# Fly-by DMA Access Decoder

This block sits between a shared host bus and the data FIFO of an image compression coprocessor. It turns asynchronous chip-select, DMA-acknowledge, read and write strobes into single-cycle internal pulses. A normal register access produces a register read or register write pulse. A self-initiated single-address (fly-by) DMA access produces a push or pop of pixel or code-block data. In fly-by operation the coprocessor only watches a transfer between the host and another peripheral. For that reason the read and write strobes are swapped or ignored, depending on the operating direction (encode or decode) and the load state (load or unload).

The block keeps a word count for the data FIFO. The host side of the FIFO is driven by the decoded fly-by pulses, and the core side by two one-cycle inputs. From that count it raises a DMA request whenever the FIFO can take a word (load) or give one (unload). A push into a full FIFO, or a pop from an empty one, is dropped and latches a sticky error flag.

Top module: `flyby_access_decoder`

## Requirements
- R1: With `chipSel`=1 and `dmaAck`=0, a rising read strobe gives one `regRd` pulse and a rising write strobe gives one `regWr` pulse, in every mode and state. If both strobes rise in the same cycle, only `regRd` is produced.
- R2: When `dmaAck`=1 it replaces chip select and takes priority over it. No register pulse is produced, even if `chipSel`=1.
- R3: Fly-by with `modeDecode`=0 (encode) and `stateUnload`=0 (load): a rising read strobe gives one `pixPush` pulse, and the write strobe has no effect.
- R4: Fly-by with encode and `stateUnload`=1 (unload): a rising write strobe gives one `cbPop` pulse, and the read strobe has no effect.
- R5: Fly-by with `modeDecode`=1 (decode) and load: a rising read strobe gives one `cbPush` pulse, and the write strobe has no effect.
- R6: Fly-by with decode and unload: a rising write strobe gives one `pixPop` pulse, and the read strobe has no effect.
- R7: Each strobe assertion gives exactly one output pulse, one cycle wide. The pulse appears SYNC_STAGES rising clock edges after the strobe rises (2 by default). At most one of the six pulse outputs is high in any cycle.
- R8: With `chipSel`=0 and `dmaAck`=0, strobes produce no pulse.
- R9: `fifoLevel` counts accepted words, from 0 to DEPTH.
  - In load state, `pixPush`/`cbPush` add one and `coreTake` removes one; `coreGive` has no effect.
  - In unload state, `coreGive` adds one and `pixPop`/`cbPop` remove one; `coreTake` has no effect.
  - The count changes on the clock edge that ends the pulse.
- R10: `dmaReq` is high in load state while `fifoLevel`<DEPTH and in unload state while `fifoLevel`>0. It falls together with the count update that fills or empties the FIFO.
- R11: A push while `fifoLevel`=DEPTH, or a pop while `fifoLevel`=0, leaves the count unchanged and sets `fifoErr`. `fifoErr` stays set until reset.
- R12: While `rstN`=0 and after its release, `fifoLevel`=0, `fifoErr`=0 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Host chip select, active high, asynchronous |
| dmaAck | input | 1 | DMA acknowledge, active high, asynchronous; marks a fly-by cycle |
| rdStb | input | 1 | Shared bus read strobe, active high, asynchronous |
| wrStb | input | 1 | Shared bus write strobe, active high, asynchronous |
| modeDecode | input | 1 | 0 = encode, 1 = decode (quasi-static) |
| stateUnload | input | 1 | 0 = load, 1 = unload (quasi-static) |
| coreGive | input | 1 | Core deposits one word into the FIFO (unload state) |
| coreTake | input | 1 | Core removes one word from the FIFO (load state) |
| dmaReq | output | 1 | DMA request |
| regRd | output | 1 | Register read pulse |
| regWr | output | 1 | Register write pulse |
| pixPush | output | 1 | Pixel word written into the FIFO |
| pixPop | output | 1 | Pixel word read from the FIFO |
| cbPush | output | 1 | Code-block word written into the FIFO |
| cbPop | output | 1 | Code-block word read from the FIFO |
| fifoLevel | output | $clog2(DEPTH+1) | FIFO word count |
| fifoErr | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check the following on every cycle:
- the pulse outputs stay one-hot-or-idle and one cycle wide;
- each fly-by pulse only occurs in the mode and load state it belongs to;
- the word count moves by at most one and never passes DEPTH;
- the error flag never clears and the request is low when an unload finds the FIFO empty.

Some behaviour can only be shown by the bench scenarios. These are the exact pulse latency, the strobes that must be ignored, the priority of acknowledge over chip select, the read-over-write tie-break, and the cycle in which the request falls at the full and empty boundaries.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

  // Decoded pulses presented at the block boundary
  typedef struct packed {
    logic regRd;
    logic regWr;
    logic pixPush;
    logic pixPop;
    logic cbPush;
    logic cbPop;
  } accessStb_t;

  // Strobes from control to the level-tracking datapath
  typedef struct packed {
    logic hostPush;
    logic hostPop;
  } fifoStb_t;

  // Fly-by route selected by {modeDecode, stateUnload}
  typedef enum logic [1:0] {
    RT_ENC_LOAD   = 2'b00,
    RT_ENC_UNLOAD = 2'b01,
    RT_DEC_LOAD   = 2'b10,
    RT_DEC_UNLOAD = 2'b11
  } flyRoute_e;

endpackage

// File: rtl/flyby_strobe_ctrl.sv
module flyby_strobe_ctrl
  import flyby_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSel,
  input  logic       dmaAck,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic       modeDecode,
  input  logic       stateUnload,
  output accessStb_t accStb,
  output fifoStb_t   fifoStb
);

  localparam int LINES = 4;
  localparam int TAP   = SYNC_STAGES - 1;

  logic [LINES-1:0] rawBus;
  logic [LINES-1:0] syncPipe [SYNC_STAGES];
  logic             rdNow, wrNow, csNow, ackNow;
  logic             rdLast, wrLast;
  logic             rdEdge, wrEdge;
  flyRoute_e        route;

  assign rawBus = {dmaAck, chipSel, wrStb, rdStb};

  // Synchronizer chain, one register rank per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[g] <= '0;
        else       syncPipe[g] <= rawBus;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[g] <= '0;
        else       syncPipe[g] <= syncPipe[g-1];
      end
    end
  end

  assign rdNow  = syncPipe[TAP][0];
  assign wrNow  = syncPipe[TAP][1];
  assign csNow  = syncPipe[TAP][2];
  assign ackNow = syncPipe[TAP][3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLast <= 1'b0;
      wrLast <= 1'b0;
    end else begin
      rdLast <= rdNow;
      wrLast <= wrNow;
    end
  end

  assign rdEdge = rdNow & ~rdLast;
  assign wrEdge = wrNow & ~wrLast;
  assign route  = flyRoute_e'({modeDecode, stateUnload});

  always_comb begin
    accStb = '0;
    if (ackNow) begin
      // Fly-by: acknowledge acts as select, strobes are reinterpreted
      unique case (route)
        RT_ENC_LOAD:   accStb.pixPush = rdEdge;
        RT_ENC_UNLOAD: accStb.cbPop   = wrEdge;
        RT_DEC_LOAD:   accStb.cbPush  = rdEdge;
        RT_DEC_UNLOAD: accStb.pixPop  = wrEdge;
        default:       accStb = '0;
      endcase
    end else if (csNow) begin
      accStb.regRd = rdEdge;
      accStb.regWr = wrEdge & ~rdEdge;
    end
  end

  assign fifoStb.hostPush = accStb.pixPush | accStb.cbPush;
  assign fifoStb.hostPop  = accStb.pixPop  | accStb.cbPop;

endmodule

// File: rtl/flyby_level_track.sv
module flyby_level_track
  import flyby_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStb_t         fifoStb,
  input  logic             stateUnload,
  input  logic             coreGive,
  input  logic             coreTake,
  output logic [LVL_W-1:0] level,
  output logic             dmaReq,
  output logic             errFlag
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic pushReq, popReq, isFull, isEmpty, pushOk, popOk, dropped;

  // One push source and one pop source per load state
  assign pushReq = stateUnload ? coreGive        : fifoStb.hostPush;
  assign popReq  = stateUnload ? fifoStb.hostPop : coreTake;

  assign isFull  = (level == FULL_LVL);
  assign isEmpty = (level == '0);
  assign pushOk  = pushReq & ~isFull;
  assign popOk   = popReq  & ~isEmpty;
  assign dropped = (pushReq & isFull) | (popReq & isEmpty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (pushOk && !popOk)      level <= level + 1'b1;
      else if (popOk && !pushOk) level <= level - 1'b1;
      if (dropped) errFlag <= 1'b1;
    end
  end

  assign dmaReq = stateUnload ? ~isEmpty : ~isFull;

endmodule

// File: rtl/flyby_access_decoder.sv
module flyby_access_decoder
  import flyby_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         chipSel,
  input  logic                         dmaAck,
  input  logic                         rdStb,
  input  logic                         wrStb,
  input  logic                         modeDecode,
  input  logic                         stateUnload,
  input  logic                         coreGive,
  input  logic                         coreTake,
  output logic                         dmaReq,
  output logic                         regRd,
  output logic                         regWr,
  output logic                         pixPush,
  output logic                         pixPop,
  output logic                         cbPush,
  output logic                         cbPop,
  output logic [$clog2(DEPTH+1)-1:0]   fifoLevel,
  output logic                         fifoErr
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  accessStb_t accStb;
  fifoStb_t   fifoStb;

  flyby_strobe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .dmaAck(dmaAck),
    .rdStb(rdStb), .wrStb(wrStb), .modeDecode(modeDecode),
    .stateUnload(stateUnload), .accStb(accStb), .fifoStb(fifoStb)
  );

  flyby_level_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_track (
    .clk(clk), .rstN(rstN), .fifoStb(fifoStb), .stateUnload(stateUnload),
    .coreGive(coreGive), .coreTake(coreTake), .level(fifoLevel),
    .dmaReq(dmaReq), .errFlag(fifoErr)
  );

  assign regRd   = accStb.regRd;
  assign regWr   = accStb.regWr;
  assign pixPush = accStb.pixPush;
  assign pixPop  = accStb.pixPop;
  assign cbPush  = accStb.cbPush;
  assign cbPop   = accStb.cbPop;

endmodule

// File: rtl/flyby_access_decoder_chk.sv
module flyby_access_decoder_chk #(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeDecode,
  input logic             stateUnload,
  input logic             dmaReq,
  input logic             regRd,
  input logic             regWr,
  input logic             pixPush,
  input logic             pixPop,
  input logic             cbPush,
  input logic             cbPop,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             fifoErr
);

  logic [5:0] pulses;
  assign pulses = {regRd, regWr, pixPush, pixPop, cbPush, cbPop};

  // R7
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulses != 6'b0) |=> (pulses == 6'b0));

  // R3
  pix_push_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixPush |-> (!modeDecode && !stateUnload));

  // R4
  cb_pop_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    cbPop |-> (!modeDecode && stateUnload));

  // R5
  cb_push_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    cbPush |-> (modeDecode && !stateUnload));

  // R6
  pix_pop_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixPop |-> (modeDecode && stateUnload));

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoLevel) <= DEPTH);

  // R9
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fifoLevel) == int'($past(fifoLevel)))
    || (int'(fifoLevel) == int'($past(fifoLevel)) + 1)
    || (int'(fifoLevel) == int'($past(fifoLevel)) - 1));

  // R10
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateUnload && fifoLevel == '0) |-> !dmaReq);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoErr |=> fifoErr);

endmodule

bind flyby_access_decoder flyby_access_decoder_chk #(
  .DEPTH(DEPTH), .LVL_W($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rstN(rstN), .modeDecode(modeDecode), .stateUnload(stateUnload),
  .dmaReq(dmaReq), .regRd(regRd), .regWr(regWr), .pixPush(pixPush),
  .pixPop(pixPop), .cbPush(cbPush), .cbPop(cbPop), .fifoLevel(fifoLevel),
  .fifoErr(fifoErr)
);

// File: tb/flyby_access_decoder_tb.sv
module flyby_access_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int SYNC       = 2;
  localparam int LVL_W      = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 0, dmaAck = 0, rdStb = 0, wrStb = 0;
  logic modeDecode = 0, stateUnload = 0, coreGive = 0, coreTake = 0;
  logic dmaReq, regRd, regWr, pixPush, pixPop, cbPush, cbPop, fifoErr;
  logic [LVL_W-1:0] fifoLevel;
  logic [5:0] stbVec;

  int testCnt = 0;
  int failCnt = 0;
  int expLevel = 0;
  bit expErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_access_decoder #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .dmaAck(dmaAck),
    .rdStb(rdStb), .wrStb(wrStb), .modeDecode(modeDecode),
    .stateUnload(stateUnload), .coreGive(coreGive), .coreTake(coreTake),
    .dmaReq(dmaReq), .regRd(regRd), .regWr(regWr), .pixPush(pixPush),
    .pixPop(pixPop), .cbPush(cbPush), .cbPop(cbPop),
    .fifoLevel(fifoLevel), .fifoErr(fifoErr)
  );

  // bit order: {regRd, regWr, pixPush, pixPop, cbPush, cbPop}
  assign stbVec = {regRd, regWr, pixPush, pixPop, cbPush, cbPop};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expVec(bit md, bit st, bit cs, bit ack, bit isWr);
    if (ack) begin
      case ({md, st})
        2'b00:   return isWr ? 6'b0 : 6'b001000;
        2'b01:   return isWr ? 6'b000001 : 6'b0;
        2'b10:   return isWr ? 6'b0 : 6'b000010;
        default: return isWr ? 6'b000100 : 6'b0;
      endcase
    end
    if (cs) return isWr ? 6'b010000 : 6'b100000;
    return 6'b0;
  endfunction

  function automatic string tagFor(bit md, bit st, bit cs, bit ack);
    if (ack && cs) return "R2";
    if (ack) begin
      case ({md, st})
        2'b00:   return "R3";
        2'b01:   return "R4";
        2'b10:   return "R5";
        default: return "R6";
      endcase
    end
    if (cs) return "R1";
    return "R8";
  endfunction

  // Apply the effect of one accepted/rejected host word to the model (R9, R11)
  task automatic modelHost(input logic [5:0] v);
    if (v[3] | v[1]) begin
      if (expLevel == DEPTH) expErr = 1; else expLevel++;
    end
    if (v[2] | v[0]) begin
      if (expLevel == 0) expErr = 1; else expLevel--;
    end
  endtask

  task automatic setup(input bit md, input bit st, input bit cs, input bit ack);
    @(negedge clk);
    modeDecode = md; stateUnload = st; chipSel = cs; dmaAck = ack;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic doStrobe(input bit rd, input bit wr, output logic [5:0] firstVec,
                          output int firstIdx, output int pulses);
    rdStb = rd; wrStb = wr;
    firstIdx = -1; pulses = 0; firstVec = '0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (stbVec != 6'b0) begin
        pulses++;
        if (firstIdx < 0) begin firstIdx = i; firstVec = stbVec; end
      end
    end
    rdStb = 0; wrStb = 0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic checkFifo(input string req);
    chk(int'(fifoLevel) == expLevel, req, int'(fifoLevel), expLevel);
    chk(fifoErr == expErr, "R11", fifoErr, expErr);
    chk(dmaReq == (stateUnload ? (expLevel > 0) : (expLevel < DEPTH)),
        "R10", dmaReq, stateUnload ? (expLevel > 0) : (expLevel < DEPTH));
  endtask

  task automatic flyWord(input bit isWr, input string req);
    logic [5:0] v; int idx, np;
    doStrobe(!isWr, isWr, v, idx, np);
    modelHost(v);
    chk(np == 1, req, np, 1);
    checkFifo(req);
  endtask

  task automatic corePulse(input bit give);
    @(negedge clk);
    coreGive = give; coreTake = !give;
    @(negedge clk);
    coreGive = 0; coreTake = 0;
  endtask

  initial begin
    logic [5:0] v, e;
    int idx, np;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk(int'(fifoLevel) == 0, "R12", int'(fifoLevel), 0);
    chk(fifoErr == 0, "R12", fifoErr, 0);
    chk(stbVec == 0, "R12", stbVec, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(stbVec == 0 && fifoLevel == 0, "R12", stbVec, 0);
    chk(dmaReq == 1, "R10", dmaReq, 1);

    // Sweep every mode/state/select/strobe combination
    for (int md = 0; md < 2; md++)
      for (int st = 0; st < 2; st++)
        for (int sel = 0; sel < 4; sel++)
          for (int w = 0; w < 2; w++) begin
            setup(md[0], st[0], sel[0], sel[1]);
            e = expVec(md[0], st[0], sel[0], sel[1], w[0]);
            doStrobe(!w[0], w[0], v, idx, np);
            modelHost(v);
            chk(v == e, tagFor(md[0], st[0], sel[0], sel[1]), v, e);
            chk(np == ((e != 0) ? 1 : 0), "R7", np, (e != 0) ? 1 : 0);
            if (e != 0) chk(idx == SYNC, "R7", idx, SYNC);
            checkFifo("R9");
          end

    // R1: simultaneous read and write in register mode -> read only
    setup(1'b0, 1'b0, 1'b1, 1'b0);
    doStrobe(1'b1, 1'b1, v, idx, np);
    chk(v == 6'b100000 && np == 1, "R1", v, 6'b100000);

    // Fill in encode/load until full, then overflow (R9, R10, R11)
    setup(1'b0, 1'b0, 1'b0, 1'b1);
    while (expLevel < DEPTH) flyWord(1'b0, "R9");
    chk(dmaReq == 0, "R10", dmaReq, 0);
    flyWord(1'b0, "R11");

    // Core take in load lowers the count; core give in load is ignored (R9)
    corePulse(1'b1);
    checkFifo("R9");
    corePulse(1'b0);
    expLevel--;
    checkFifo("R9");

    // Unload: drain by fly-by write strobes, then underflow (R4, R10, R11)
    setup(1'b0, 1'b1, 1'b0, 1'b1);
    while (expLevel > 0) flyWord(1'b1, "R4");
    chk(dmaReq == 0, "R10", dmaReq, 0);
    flyWord(1'b1, "R11");

    // Reset clears the sticky flag (R11, R12)
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    expLevel = 0; expErr = 0;
    @(negedge clk);
    checkFifo("R12");

    // Underflow alone sets the flag; core give in unload fills (R9, R11)
    setup(1'b1, 1'b1, 1'b0, 1'b1);
    flyWord(1'b1, "R11");
    corePulse(1'b1);
    expLevel++;
    checkFifo("R9");
    corePulse(1'b0);
    checkFifo("R9");
    flyWord(1'b1, "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule